// File: doc/BRIEF.md
# Write-Only Two-Wire Configuration Slave

This block is a receive-only slave on a two-wire serial bus (clock line and open-drain data line). It samples both lines with the system clock, cleans them up, detects bus start and stop conditions, and loads a bank of six 8-bit control registers. The registers drive the neighbouring clock-control logic. Bits 1:0 of the first register are also brought out on their own as the spread-spectrum mode.

A transfer to this block is one fixed-length write frame of eleven bytes. The frame starts with the address byte. Next come a command byte and a count byte, which the slave takes in and discards. Eight data bytes follow. Only the first six data bytes are kept. Nothing can be read back. The registers start at known defaults, so the host has to write them only when it wants something other than the defaults. The slave answers each byte with an acknowledge, but only after the address has matched.

Top module: `twowire_cfg_slave`

## Requirements
- R1: After reset, register i appears on `regsOut[8*i+7:8*i]`. Register 0 holds 8'h00 and registers 1 to 5 hold 8'hFF. `sdaLow` is 0.
- R2: A frame is accepted only when its first byte, received MSB first, equals 8'hD2 (seven address bits followed by a 0 write-direction bit). Any other first byte, 8'hD3 included, gets no acknowledge and leaves every register unchanged.
- R3: In an accepted frame, byte positions 1 and 2 have no effect whatever their values. Data bytes 0 to 5, at byte positions 3 to 8, are written to registers 0 to 5.
- R4: Data bytes 6 and 7, at byte positions 9 and 10, are received and acknowledged but change no register.
- R5: After a matching address, the slave holds the data line low (`sdaLow`=1) through the ninth clock of every byte, all eleven included. It asserts that hold only while the clock line is low.
- R6: A data byte is committed to its register as soon as its eighth bit has been sampled. A stop that arrives later in the frame leaves the registers already written intact and the rest at their old values.
- R7: A start condition while a frame is in progress (a repeated start) abandons that frame. The byte count restarts at the address byte, so the next frame loads registers from data byte 0.
- R8: `spreadMode` always equals bits 1:0 of register 0.
- R9: A start is the data line falling while the clock line is high, and a stop is the data line rising while the clock line is high. A pulse on either line that is shorter than FILT_LEN system clocks is ignored, so a one-cycle clock spike adds no bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus |
| rstN | input | 1 | Active-low reset, loads the register defaults |
| sclIn | input | 1 | Serial clock line as seen at the pad |
| sdaIn | input | 1 | Serial data line as seen at the pad (wired bus level) |
| sdaLow | output | 1 | 1 = pull the data line low (acknowledge) |
| regsOut | output | 48 | Six control registers, register i at bits 8*i+7:8*i |
| spreadMode | output | 2 | Spread-spectrum mode, bits 1:0 of register 0 |

## Verification
Two cases are hard to reach from the ports: a frame cut short partway through, and a repeated start that comes while the byte counter is in the middle of the data bytes. For these the bench uses a bit-level bus master whose frame task can stop after any number of data bytes, and which can either close with a stop or go straight into a new start with no stop in between. A third case needs a one-cycle spike on the clock line during the low phase of a bit. The bench injects it in the middle of a frame and then checks that every register still lands on the expected value, which shows that no extra bit shifted the byte alignment.

// File: rtl/cfgs_pkg.sv
`timescale 1ns/1ps
package cfgs_pkg;
  localparam int IDX_W = 3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DATA,
    ST_ACK_SETUP,
    ST_ACK_HOLD,
    ST_SKIP
  } ctrlState_t;

  typedef struct packed {
    logic             shiftEn;
    logic             bitVal;
    logic             commit;
    logic [IDX_W-1:0] idx;
  } strobe_t;
endpackage

// File: rtl/cfgs_ctrl.sv
`timescale 1ns/1ps
module cfgs_ctrl #(
  parameter int       FILT_LEN    = 3,
  parameter bit [7:0] SLAVE_ADDR  = 8'hD2,
  parameter int       FRAME_BYTES = 11,
  parameter int       FIRST_REG   = 3,
  parameter int       NUM_REGS    = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sclIn,
  input  logic             sdaIn,
  input  logic [6:0]       shLow,
  output cfgs_pkg::strobe_t stb,
  output logic             sdaLow
);
  import cfgs_pkg::*;

  localparam int BIDX_W = $clog2(FRAME_BYTES);
  localparam int FCNT_W = $clog2(FILT_LEN + 1);

  logic [1:0] rawIn;
  logic [1:0] filt;
  assign rawIn = {sdaIn, sclIn};

  // two-flop synchronizer plus persistence filter, one per bus line
  for (genvar g = 0; g < 2; g++) begin : gLine
    logic [1:0]        syncQ;
    logic [FCNT_W-1:0] cnt;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        syncQ   <= 2'b11;
        cnt     <= '0;
        filt[g] <= 1'b1;
      end else begin
        syncQ <= {syncQ[0], rawIn[g]};
        if (syncQ[1] != filt[g]) begin
          if (cnt == FCNT_W'(FILT_LEN - 1)) begin
            filt[g] <= syncQ[1];
            cnt     <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end else begin
          cnt <= '0;
        end
      end
    end
  end

  logic sclF, sdaF, sclPrev, sdaPrev;
  assign sclF = filt[0];
  assign sdaF = filt[1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPrev <= sclF;
      sdaPrev <= sdaF;
    end
  end

  logic sclRise, sclFall, startC, stopC;
  assign sclRise = sclF & ~sclPrev;
  assign sclFall = ~sclF & sclPrev;
  assign startC  = sclF & sclPrev & sdaPrev & ~sdaF;
  assign stopC   = sclF & sclPrev & ~sdaPrev & sdaF;

  ctrlState_t        state;
  logic [2:0]        bitCnt;
  logic [BIDX_W-1:0] byteIdx;
  logic              lastBit;

  always_comb begin
    stb.shiftEn = (state == ST_DATA) && sclRise;
    stb.bitVal  = sdaF;
    lastBit     = stb.shiftEn && (bitCnt == 3'd7);
    stb.commit  = lastBit && (byteIdx >= BIDX_W'(FIRST_REG))
                          && (byteIdx <  BIDX_W'(FIRST_REG + NUM_REGS));
    stb.idx     = IDX_W'(byteIdx - BIDX_W'(FIRST_REG));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      bitCnt  <= '0;
      byteIdx <= '0;
      sdaLow  <= 1'b0;
    end else if (startC) begin
      state   <= ST_DATA;
      bitCnt  <= '0;
      byteIdx <= '0;
      sdaLow  <= 1'b0;
    end else if (stopC) begin
      state  <= ST_IDLE;
      sdaLow <= 1'b0;
    end else begin
      unique case (state)
        ST_DATA: if (stb.shiftEn) begin
          bitCnt <= bitCnt + 1'b1;
          if (lastBit) begin
            if (byteIdx == '0 && {shLow, sdaF} != SLAVE_ADDR) state <= ST_SKIP;
            else                                              state <= ST_ACK_SETUP;
          end
        end
        ST_ACK_SETUP: if (sclFall) begin
          state  <= ST_ACK_HOLD;
          sdaLow <= 1'b1;
        end
        ST_ACK_HOLD: if (sclFall) begin
          sdaLow <= 1'b0;
          if (byteIdx == BIDX_W'(FRAME_BYTES - 1)) begin
            state <= ST_SKIP;
          end else begin
            state   <= ST_DATA;
            byteIdx <= byteIdx + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  // R5: acknowledge is only ever raised while the clock line is low
  a_r5_ack_on_low: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaLow) |-> !sclF);
  // R2: no drive on the data line when no frame is active
  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE) |-> !sdaLow);
  // R7: a start rewinds the frame position
  a_r7_restart_clears: assert property (@(posedge clk) disable iff (!rstN)
    startC |=> (byteIdx == '0 && bitCnt == '0 && !sdaLow));
endmodule

// File: rtl/cfgs_dp.sv
`timescale 1ns/1ps
module cfgs_dp #(
  parameter int                   NUM_REGS = 6,
  parameter int                   REG_W    = 8,
  parameter logic [NUM_REGS*REG_W-1:0] DEFAULTS = '0
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  cfgs_pkg::strobe_t         stb,
  output logic [REG_W-2:0]          shLow,
  output logic [NUM_REGS*REG_W-1:0] regsOut
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            shLow <= '0;
    else if (stb.shiftEn) shLow <= {shLow[REG_W-3:0], stb.bitVal};
  end

  for (genvar i = 0; i < NUM_REGS; i++) begin : gReg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        regsOut[i*REG_W +: REG_W] <= DEFAULTS[i*REG_W +: REG_W];
      else if (stb.commit && stb.idx == cfgs_pkg::IDX_W'(i))
        regsOut[i*REG_W +: REG_W] <= {shLow, stb.bitVal};
    end
  end

  // R4/R6: registers move only on a commit strobe
  a_r4_regs_hold: assert property (@(posedge clk) disable iff (!rstN)
    !stb.commit |=> $stable(regsOut));
  // R3: commits target an existing register
  a_r3_idx_range: assert property (@(posedge clk) disable iff (!rstN)
    stb.commit |-> (int'(stb.idx) < NUM_REGS));
endmodule

// File: rtl/twowire_cfg_slave.sv
`timescale 1ns/1ps
module twowire_cfg_slave #(
  parameter bit [7:0] SLAVE_ADDR = 8'hD2,
  parameter int       FILT_LEN   = 3,
  parameter int       NUM_REGS   = 6,
  parameter logic [NUM_REGS*8-1:0] DEFAULTS = 48'hFFFF_FFFF_FF00
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  sclIn,
  input  logic                  sdaIn,
  output logic                  sdaLow,
  output logic [NUM_REGS*8-1:0] regsOut,
  output logic [1:0]            spreadMode
);
  cfgs_pkg::strobe_t stb;
  logic [6:0]        shLow;

  cfgs_ctrl #(
    .FILT_LEN(FILT_LEN), .SLAVE_ADDR(SLAVE_ADDR),
    .FRAME_BYTES(11), .FIRST_REG(3), .NUM_REGS(NUM_REGS)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .shLow(shLow), .stb(stb), .sdaLow(sdaLow)
  );

  cfgs_dp #(.NUM_REGS(NUM_REGS), .REG_W(8), .DEFAULTS(DEFAULTS)) uDp (
    .clk(clk), .rstN(rstN), .stb(stb), .shLow(shLow), .regsOut(regsOut)
  );

  assign spreadMode = regsOut[1:0]; // R8
endmodule

// File: tb/sim_twowire_cfg_slave.sv
`timescale 1ns/1ps
module sim_twowire_cfg_slave;
  localparam int Q = 10;
  localparam logic [47:0] DEF = 48'hFFFF_FFFF_FF00;

  logic clk = 0, rstN = 0, sclM = 1, sdaM = 1;
  logic sdaLow;
  logic [47:0] regsOut;
  logic [1:0]  spreadMode;
  logic sdaBus;
  assign sdaBus = sdaM & ~sdaLow;

  twowire_cfg_slave u0 (.clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaBus),
    .sdaLow(sdaLow), .regsOut(regsOut), .spreadMode(spreadMode));

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0;
  bit finished = 0;
  logic [7:0] d [8];
  logic [47:0] expRegs;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitQ(); repeat (Q) @(negedge clk); endtask

  task automatic startCond();
    sdaM = 1; waitQ(); sclM = 1; waitQ(); sdaM = 0; waitQ(); sclM = 0; waitQ();
  endtask

  task automatic stopCond();
    sdaM = 0; waitQ(); sclM = 1; waitQ(); sdaM = 1; waitQ(); waitQ();
  endtask

  task automatic sendByte(input logic [7:0] b, input bit glitch, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sdaM = b[i];
      if (glitch && i == 3) begin
        @(negedge clk) sclM = 1;
        @(negedge clk) sclM = 0;
      end
      waitQ(); sclM = 1; waitQ(); waitQ(); sclM = 0; waitQ();
    end
    sdaM = 1; waitQ(); sclM = 1; waitQ();
    ack = (sdaBus == 1'b0);
    waitQ(); sclM = 0; waitQ();
  endtask

  // sends addr, cmd, count, then nData bytes of d[]; returns acknowledge count
  task automatic sendFrame(input logic [7:0] addr, input logic [7:0] cmd, input logic [7:0] cnt,
                           input int nData, input bit glitch, input bit withStop, output int acks);
    bit a;
    acks = 0;
    startCond();
    sendByte(addr, 0, a); acks += a;
    sendByte(cmd, 0, a);  acks += a;
    sendByte(cnt, 0, a);  acks += a;
    for (int k = 0; k < nData; k++) begin
      sendByte(d[k], glitch && k == 2, a); acks += a;
    end
    if (withStop) stopCond();
    repeat (20) @(negedge clk);
  endtask

  task automatic tReset();
    check("R1 reset regs", regsOut, DEF);
    check("R1 reset sdaLow", sdaLow, 0);
    check("R8 reset spreadMode", spreadMode, 2'b00);
  endtask

  task automatic tFullFrame();
    int acks;
    d = '{8'h03, 8'h12, 8'h34, 8'h56, 8'h78, 8'h9A, 8'hBC, 8'hDE};
    sendFrame(8'hD2, 8'h00, 8'h08, 8, 0, 1, acks);
    expRegs = {d[5], d[4], d[3], d[2], d[1], d[0]};
    check("R5 acks on full frame", acks, 11);
    check("R3 regs after full frame", regsOut, expRegs);
    check("R8 spreadMode", spreadMode, 2'b11);
    // same data 0..5, different cmd/count and data 6/7
    d[6] = 8'h00; d[7] = 8'h55;
    sendFrame(8'hD2, 8'hA7, 8'h3C, 8, 0, 1, acks);
    check("R3 cmd/count ignored", regsOut, expRegs);
    check("R4 data6/7 discarded", regsOut, expRegs);
  endtask

  task automatic tBadAddr();
    int acks;
    d = '{8'h21, 8'h22, 8'h23, 8'h24, 8'h25, 8'h26, 8'h27, 8'h28};
    sendFrame(8'hD0, 8'h00, 8'h08, 8, 0, 1, acks);
    check("R2 no ack other addr", acks, 0);
    check("R2 regs untouched other addr", regsOut, expRegs);
    sendFrame(8'hD3, 8'h00, 8'h08, 8, 0, 1, acks);
    check("R2 no ack read dir", acks, 0);
    check("R2 regs untouched read dir", regsOut, expRegs);
  endtask

  task automatic tPartial();
    int acks;
    d = '{8'h41, 8'h42, 8'h43, 8'h44, 8'h45, 8'h46, 8'h47, 8'h48};
    sendFrame(8'hD2, 8'h00, 8'h08, 3, 0, 1, acks);
    expRegs[23:0] = {d[2], d[1], d[0]};
    check("R6 partial frame acks", acks, 6);
    check("R6 partial frame regs", regsOut, expRegs);
    check("R8 spreadMode partial", spreadMode, 2'b01);
  endtask

  task automatic tRestart();
    int acks;
    d = '{8'hA5, 8'hA6, 8'hA7, 8'hA8, 8'hA9, 8'hAA, 8'hAB, 8'hAC};
    sendFrame(8'hD2, 8'h00, 8'h08, 2, 0, 0, acks);   // no stop: repeated start next
    d = '{8'h60, 8'h61, 8'h62, 8'h63, 8'h64, 8'h65, 8'h66, 8'h67};
    sendFrame(8'hD2, 8'h00, 8'h08, 8, 0, 1, acks);
    expRegs = {d[5], d[4], d[3], d[2], d[1], d[0]};
    check("R7 acks after repeated start", acks, 11);
    check("R7 regs after repeated start", regsOut, expRegs);
  endtask

  task automatic tGlitch();
    int acks;
    d = '{8'h5C, 8'h3B, 8'hC4, 8'h1F, 8'hE2, 8'h70, 8'h0D, 8'h99};
    sendFrame(8'hD2, 8'h00, 8'h08, 8, 1, 1, acks);
    expRegs = {d[5], d[4], d[3], d[2], d[1], d[0]};
    check("R9 acks with clock spike", acks, 11);
    check("R9 regs with clock spike", regsOut, expRegs);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1;
    repeat (5) @(negedge clk);
    tReset();
    tFullFrame();
    tBadAddr();
    tPartial();
    tRestart();
    tGlitch();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule